// File: doc/BRIEF.md
# Pulse-Width Coded Error Link

This block carries a memory error class across a single active-low sideband wire, using the length of the low pulse as the code. The transmitter half sits next to the data path. It accepts two error strobes, one for a correctable single-bit error and one for an uncorrectable error (multi-bit or parity). A strobe counts only when the read-cycle qualifier is high in the same clock. For each accepted error the transmitter pulls the wire low for a fixed number of host clocks. The narrow code marks a correctable error and the wide code marks an uncorrectable one.

The receiver half sits on the controller side and shares the same host clock. It counts how many clocks the wire stays low. When the wire returns high it classifies the pulse and emits a one-clock flag. An exact narrow width gives the correctable flag and an exact wide width gives the uncorrectable flag. Any other width gives a protocol flag. The transmitter output and the receiver input are separate ports, so the two halves can be chained directly or the receiver can be driven by another agent. Errors that arrive while a pulse is on the wire are held pending and sent after a fixed idle gap.

Top module: `pwc_err_link`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge) `errLineN` is 1 and `sbeFlag`, `ueFlag` and `protoFlag` are 0.
- R2: `sbeStrobe` and `mbeStrobe` have no effect when `rdCycle` is 0 in the same clock: no pulse is sent and nothing is held pending.
- R3: A qualified `sbeStrobe` sampled at edge E, with the transmitter idle, drives `errLineN` low from E for exactly SBE_WIDTH (default 5) clocks.
- R4: A qualified `mbeStrobe` sampled at edge E, with the transmitter idle, drives `errLineN` low from E for exactly UE_WIDTH (default 6) clocks.
- R5: When both strobes are qualified in the same clock, a single UE_WIDTH pulse is sent and that single-bit report is discarded.
- R6: An error accepted while a pulse or gap is in progress is held pending and sent after exactly GAP_CLKS (default 1) high clocks. A pending uncorrectable error is sent before a pending correctable one. Repeats of one class while pending merge into one pulse.
- R7: When `lineInN` is sampled low at exactly SBE_WIDTH consecutive edges and then high at edge F, `sbeFlag` is 1 for the single clock after F.
- R8: When `lineInN` is sampled low at exactly UE_WIDTH consecutive edges and then high at edge F, `ueFlag` is 1 for the single clock after F.
- R9: A low run of any other length (1, 4, 7, 11 clocks and so on) raises `protoFlag` for the single clock after its end. A run counter saturates rather than wrapping.
- R10: The three receiver flags are never high together, none is high for two consecutive clocks, and back-to-back pulses separated by one high clock are each classified.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared host clock |
| rst | input | 1 | Synchronous reset, active high |
| rdCycle | input | 1 | Qualifier: a memory read cycle is in progress |
| sbeStrobe | input | 1 | Single-bit correctable error detected |
| mbeStrobe | input | 1 | Multi-bit or parity error detected |
| errLineN | output | 1 | Transmitted sideband wire, active low |
| lineInN | input | 1 | Received sideband wire, active low |
| sbeFlag | output | 1 | One-clock pulse: correctable-width pulse received |
| ueFlag | output | 1 | One-clock pulse: uncorrectable-width pulse received |
| protoFlag | output | 1 | One-clock pulse: pulse of illegal width received |

## Verification
Two transmitter functions can land in one clock. One is two error classes reported together. The other is a fresh error arriving while another is still pending, just as the gap expires. The first is provoked by raising both strobes on one qualified clock. The check then looks for exactly one wide pulse and no correctable flag. The second is provoked by injecting an uncorrectable strobe and two correctable strobes in the middle of a narrow pulse. The captured wire trace must show narrow, gap, wide, gap, narrow, and the receiver flags must fall at the cycles derived from those widths. On the receiver side, the classification of one pulse coincides with the start of the next when injected pulses are one clock apart, and both flags are checked.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  typedef struct packed {
    logic loadPulse;
    logic wideCode;
    logic loadGap;
  } txStrobe_t;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_BUSY = 2'd1,
    TX_GAP  = 2'd2
  } txState_t;
endpackage

// File: rtl/pwc_tx_ctrl.sv
module pwc_tx_ctrl
  import pwc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      rdCycle,
  input  logic      sbeStrobe,
  input  logic      mbeStrobe,
  input  logic      cntZero,
  output txStrobe_t strobe
);
  txState_t state, stateNext;
  logic pendUe, pendSbe;
  logic newUe, newSbe, reqUe, reqSbe, canStart, startNow;

  always_comb begin
    newUe    = rdCycle & mbeStrobe;
    newSbe   = rdCycle & sbeStrobe & ~mbeStrobe;
    reqUe    = pendUe | newUe;
    reqSbe   = pendSbe | newSbe;
    canStart = (state == TX_IDLE) || ((state == TX_GAP) && cntZero);
    startNow = canStart && (reqUe || reqSbe);

    strobe.loadPulse = startNow;
    strobe.wideCode  = reqUe;
    strobe.loadGap   = (state == TX_BUSY) && cntZero;

    stateNext = state;
    case (state)
      TX_IDLE: if (startNow) stateNext = TX_BUSY;
      TX_BUSY: if (cntZero) stateNext = TX_GAP;
      TX_GAP:  if (cntZero) stateNext = startNow ? TX_BUSY : TX_IDLE;
      default: stateNext = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= TX_IDLE;
      pendUe  <= 1'b0;
      pendSbe <= 1'b0;
    end else begin
      state   <= stateNext;
      pendUe  <= (startNow && reqUe) ? 1'b0 : reqUe;
      pendSbe <= (startNow && !reqUe) ? 1'b0 : reqSbe;
    end
  end

  // R2: nothing starts from unqualified strobes
  assert_ignore_unqualified_R2: assert property (@(posedge clk) disable iff (rst)
    (!rdCycle && state == TX_IDLE && !pendUe && !pendSbe) |-> !strobe.loadPulse);

  // R5: simultaneous classes send the wide code
  assert_wide_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (rdCycle && mbeStrobe && strobe.loadPulse) |-> strobe.wideCode);

  // R6: an uncorrectable error during a pulse is retained
  assert_pending_kept_R6: assert property (@(posedge clk) disable iff (rst)
    (state == TX_BUSY && rdCycle && mbeStrobe) |=> pendUe);
endmodule

// File: rtl/pwc_tx_dp.sv
module pwc_tx_dp
  import pwc_pkg::*;
#(
  parameter int SBE_WIDTH = 5,
  parameter int UE_WIDTH  = 6,
  parameter int GAP_CLKS  = 1
) (
  input  logic      clk,
  input  logic      rst,
  input  txStrobe_t strobe,
  output logic      errLineN,
  output logic      cntZero
);
  localparam int LONGEST = (UE_WIDTH > SBE_WIDTH) ? UE_WIDTH : SBE_WIDTH;
  localparam int SPAN    = (LONGEST > GAP_CLKS) ? LONGEST : GAP_CLKS;
  localparam int CW      = $clog2(SPAN + 1);

  logic [CW-1:0] cnt;
  logic          lineActive;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      lineActive <= 1'b0;
    end else if (strobe.loadPulse) begin
      lineActive <= 1'b1;
      cnt        <= strobe.wideCode ? CW'(UE_WIDTH - 1) : CW'(SBE_WIDTH - 1);
    end else if (strobe.loadGap) begin
      lineActive <= 1'b0;
      cnt        <= CW'(GAP_CLKS - 1);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign cntZero  = (cnt == '0);
  assign errLineN = ~lineActive;

  // checker: length of the current low run on the wire
  logic [CW:0] runLen;
  always_ff @(posedge clk) begin
    if (rst) runLen <= '0;
    else if (lineActive) runLen <= runLen + 1'b1;
    else runLen <= '0;
  end

  // R3 R4: every pulse ends at one of the two legal widths
  assert_legal_width_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(lineActive) && !lineActive) |->
      (runLen == (CW+1)'(SBE_WIDTH) || runLen == (CW+1)'(UE_WIDTH)));

  // R4: no pulse outlasts the wide code
  assert_no_overlong_R4: assert property (@(posedge clk) disable iff (rst)
    lineActive |-> (runLen < (CW+1)'(UE_WIDTH)));
endmodule

// File: rtl/pwc_rx.sv
module pwc_rx #(
  parameter int SBE_WIDTH = 5,
  parameter int UE_WIDTH  = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic lineInN,
  output logic sbeFlag,
  output logic ueFlag,
  output logic protoFlag
);
  localparam int            RW  = $clog2(UE_WIDTH + 2);
  localparam logic [RW-1:0] SAT = '1;

  logic          wasLow;
  logic [RW-1:0] lowCnt;
  logic          lineLow, pulseEnd;

  assign lineLow  = ~lineInN;
  assign pulseEnd = wasLow && !lineLow;

  always_ff @(posedge clk) begin
    if (rst) begin
      wasLow    <= 1'b0;
      lowCnt    <= '0;
      sbeFlag   <= 1'b0;
      ueFlag    <= 1'b0;
      protoFlag <= 1'b0;
    end else begin
      wasLow <= lineLow;
      if (lineLow) begin
        if (!wasLow) lowCnt <= RW'(1);
        else if (lowCnt != SAT) lowCnt <= lowCnt + 1'b1;
      end
      sbeFlag   <= pulseEnd && (lowCnt == RW'(SBE_WIDTH));
      ueFlag    <= pulseEnd && (lowCnt == RW'(UE_WIDTH));
      protoFlag <= pulseEnd && (lowCnt != RW'(SBE_WIDTH)) && (lowCnt != RW'(UE_WIDTH));
    end
  end

  // R10: classified flags are exclusive
  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sbeFlag, ueFlag, protoFlag}));

  // R10: each flag lasts one clock
  assert_sbe_single_R10: assert property (@(posedge clk) disable iff (rst)
    sbeFlag |=> !sbeFlag);
  assert_ue_single_R10: assert property (@(posedge clk) disable iff (rst)
    ueFlag |=> !ueFlag);
  assert_proto_single_R9: assert property (@(posedge clk) disable iff (rst)
    protoFlag |=> !protoFlag);

  // R7 R8 R9: a flag only follows a low-to-high return of the wire
  assert_flag_after_end_R7: assert property (@(posedge clk) disable iff (rst)
    (sbeFlag || ueFlag || protoFlag) |-> ($past(lineInN) && !$past(wasLow) == 1'b0));
endmodule

// File: rtl/pwc_err_link.sv
module pwc_err_link #(
  parameter int SBE_WIDTH = 5,
  parameter int UE_WIDTH  = 6,
  parameter int GAP_CLKS  = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic rdCycle,
  input  logic sbeStrobe,
  input  logic mbeStrobe,
  output logic errLineN,
  input  logic lineInN,
  output logic sbeFlag,
  output logic ueFlag,
  output logic protoFlag
);
  pwc_pkg::txStrobe_t txStrobe;
  logic               cntZero;

  pwc_tx_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .rdCycle   (rdCycle),
    .sbeStrobe (sbeStrobe),
    .mbeStrobe (mbeStrobe),
    .cntZero   (cntZero),
    .strobe    (txStrobe)
  );

  pwc_tx_dp #(
    .SBE_WIDTH (SBE_WIDTH),
    .UE_WIDTH  (UE_WIDTH),
    .GAP_CLKS  (GAP_CLKS)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (txStrobe),
    .errLineN (errLineN),
    .cntZero  (cntZero)
  );

  pwc_rx #(
    .SBE_WIDTH (SBE_WIDTH),
    .UE_WIDTH  (UE_WIDTH)
  ) u_rx (
    .clk       (clk),
    .rst       (rst),
    .lineInN   (lineInN),
    .sbeFlag   (sbeFlag),
    .ueFlag    (ueFlag),
    .protoFlag (protoFlag)
  );
endmodule

// File: tb/pwc_err_link_bench.sv
`timescale 1ns/1ps
module pwc_err_link_bench;
  logic clk = 1'b0;
  logic rst, rdCycle, sbeStrobe, mbeStrobe;
  logic errLineN, lineInN, sbeFlag, ueFlag, protoFlag;
  logic injEn, injVal;
  int   checks = 0;
  int   fails  = 0;
  bit   finished = 1'b0;
  logic [63:0] gotLow, gotSbe, gotUe, gotProto;

  always #2 clk = ~clk;

  assign lineInN = injEn ? injVal : errLineN;

  pwc_err_link u_pwc_err_link (
    .clk(clk), .rst(rst), .rdCycle(rdCycle), .sbeStrobe(sbeStrobe),
    .mbeStrobe(mbeStrobe), .errLineN(errLineN), .lineInN(lineInN),
    .sbeFlag(sbeFlag), .ueFlag(ueFlag), .protoFlag(protoFlag)
  );

  function automatic logic [63:0] span(input int s, input int len);
    logic [63:0] m = '0;
    for (int i = 0; i < len; i++) m[s + i] = 1'b1;
    return m;
  endfunction

  task automatic check1(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic checkTrace(input string req, input logic [63:0] eLow, input logic [63:0] eSbe,
                            input logic [63:0] eUe, input logic [63:0] eProto);
    checks += 4;
    if (gotLow !== eLow) begin fails++; $display("FAIL %s wire actual=%h expected=%h", req, gotLow, eLow); end
    if (gotSbe !== eSbe) begin fails++; $display("FAIL %s sbeFlag actual=%h expected=%h", req, gotSbe, eSbe); end
    if (gotUe !== eUe) begin fails++; $display("FAIL %s ueFlag actual=%h expected=%h", req, gotUe, eUe); end
    if (gotProto !== eProto) begin fails++; $display("FAIL %s protoFlag actual=%h expected=%h", req, gotProto, eProto); end
  endtask

  // bit k of each vector is driven before edge k+1; trace index j is sampled after edge j+1
  task automatic runSeq(input int n, input logic [63:0] rdV, input logic [63:0] sbeV,
                        input logic [63:0] ueV, input logic [63:0] injEnV, input logic [63:0] injLowV);
    gotLow = '0; gotSbe = '0; gotUe = '0; gotProto = '0;
    for (int k = 0; k <= n; k++) begin
      @(negedge clk);
      if (k > 0) begin
        gotLow[k-1]   = ~errLineN;
        gotSbe[k-1]   = sbeFlag;
        gotUe[k-1]    = ueFlag;
        gotProto[k-1] = protoFlag;
      end
      if (k < n) begin
        rdCycle = rdV[k]; sbeStrobe = sbeV[k]; mbeStrobe = ueV[k];
        injEn = injEnV[k]; injVal = ~injLowV[k];
      end else begin
        rdCycle = 0; sbeStrobe = 0; mbeStrobe = 0; injEn = 0; injVal = 1;
      end
    end
  endtask

  task automatic testReset();
    rst = 1; rdCycle = 0; sbeStrobe = 0; mbeStrobe = 0; injEn = 0; injVal = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check1("R1", "errLineN", errLineN, 1'b1);
    check1("R1", "sbeFlag", sbeFlag, 1'b0);
    check1("R1", "ueFlag", ueFlag, 1'b0);
    check1("R1", "protoFlag", protoFlag, 1'b0);
  endtask

  task automatic testIgnored();  // R2
    runSeq(16, 64'h0, 64'h5, 64'hA, 64'h0, 64'h0);
    checkTrace("R2", '0, '0, '0, '0);
  endtask

  task automatic testSbe();  // R3 and R7
    runSeq(16, 64'h1, 64'h1, 64'h0, 64'h0, 64'h0);
    checkTrace("R3_R7", span(0, 5), span(6, 1), '0, '0);
  endtask

  task automatic testUe();  // R4 and R8
    runSeq(16, 64'h1, 64'h0, 64'h1, 64'h0, 64'h0);
    checkTrace("R4_R8", span(0, 6), '0, span(7, 1), '0);
  endtask

  task automatic testBoth();  // R5
    runSeq(20, 64'h1, 64'h1, 64'h1, 64'h0, 64'h0);
    checkTrace("R5", span(0, 6), '0, span(7, 1), '0);
  endtask

  task automatic testPending();  // R6: sbe at 0, ue at 2, sbe at 3 and 4
    runSeq(28, span(0, 5), 64'h19, 64'h4, 64'h0, 64'h0);
    checkTrace("R6", span(0, 5) | span(6, 6) | span(13, 5),
               span(6, 1) | span(19, 1), span(13, 1), '0);
  endtask

  task automatic testInject(input int w);  // R7 R8 R9
    logic [63:0] eS, eU, eP;
    eS = '0; eU = '0; eP = '0;
    if (w == 5) eS = span(2 + w, 1);
    else if (w == 6) eU = span(2 + w, 1);
    else eP = span(2 + w, 1);
    runSeq(24, 64'h0, 64'h0, 64'h0, span(0, 24), span(2, w));
    checkTrace(w == 5 ? "R7" : (w == 6 ? "R8" : "R9"), '0, eS, eU, eP);
  endtask

  task automatic testBackToBack();  // R10
    runSeq(24, 64'h0, 64'h0, 64'h0, span(0, 24), span(1, 5) | span(7, 6));
    checkTrace("R10", '0, span(6, 1), span(13, 1), '0);
  endtask

  initial begin
    testReset();
    testIgnored();
    testSbe();
    testUe();
    testBoth();
    testPending();
    testInject(5);
    testInject(6);
    testInject(1);
    testInject(4);
    testInject(7);
    testInject(11);
    testBackToBack();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule